// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Control Unit

This block is the control unit of a small one-address accumulator machine, built together with the few registers it steers: a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. A 2-bit cycle-state register records which phase of the instruction cycle the machine is in. A step counter walks through that phase one clock at a time. A fixed decode table turns the pair (cycle, step) and the current opcode into a vector of gate enables and memory strobes.

The four cycle states are CYC_FETCH (00), CYC_INDIRECT (01), CYC_EXECUTE (10) and CYC_INTERRUPT (11). Their transitions are named as follows:
- FETCH_TO_INDIRECT: the fetched word has its indirect flag set.
- FETCH_TO_EXECUTE: the indirect flag is clear.
- INDIRECT_TO_EXECUTE: always.
- EXECUTE_TO_INTERRUPT: a request is pending while interrupts are enabled.
- EXECUTE_TO_FETCH: otherwise.
- INTERRUPT_TO_FETCH: always.

Every transition happens on the clock edge that ends the last step of a cycle, and the step counter then returns to 0. Execute sequences exist for an add-to-accumulator instruction and for an increment-and-skip-if-zero instruction. Any other opcode is a one-step no-op.

Memory is word addressed and sits outside the block. The address driven is always the memory address register. In a read step, the memory returns the addressed word on `mem_rdata` within that step, and it is captured at the edge that ends the step. A write happens at the edge that ends a write step.

Top module: `insn_cycle_ctrl`

## Requirements
- R1: A synchronous reset sets the cycle code to 00 (fetch), the step index to 0, PC to 0 and the accumulator to 0, and disables interrupts.
- R2: Instruction word: bit 15 is the indirect flag, bits 14:12 the opcode, bits 11:0 the address. The cycle code steps 00→01 or 00→10 after the third fetch step (01 exactly when the fetched word's bit 15 is 1), 01→10 always, 11→00 always, and 10→11 or 10→00 after the last execute step. Step indices run 0,1,2(,3) within a cycle.
- R3: Gate vector bit positions: 0 PC to MAR, 1 memory to MBR, 2 PC increment, 3 MBR to IR, 4 IR address to MAR, 5 MBR address to IR address, 6 PC to MBR, 7 save address to MAR, 8 handler address to PC, 9 MBR to memory, 10 accumulator add, 11 MBR increment, 12 conditional skip. Fetch asserts {0}, then {1,2} with a read, then {3}; PC rises by one across step 1 and IR holds the fetched word after step 2.
- R4: Indirect asserts {4}, then {1} with a read, then {5}; afterwards IR bits 11:0 equal bits 11:0 of the word read, and IR bits 15:12 are unchanged.
- R5: Opcode 000 (add) executes in three steps {4}, {1}+read, {10}; the accumulator gains the addressed word, modulo 2^16.
- R6: Opcode 001 (increment and skip) executes in four steps {4}, {1}+read, {11}, then {9}+write; it writes the word plus one back to the same address, and in that last step also asserts bit 12 and advances PC by one when the written value is zero.
- R7: Any other opcode executes in a single step with no gate and no strobe, and PC and accumulator keep their values.
- R8: Interrupt asserts {6}, then {7,8}, then {9} with a write. The PC value at entry is written to the save address, PC holds the handler address afterwards, and interrupts are disabled on entry.
- R9: A one-cycle pulse on `ien_set` enables interrupts. The request line is sampled only at the last execute step and is ignored while interrupts are disabled.
- R10: Read and write strobes are never active together. During a strobe, `mem_addr` equals the address loaded into MAR earlier in that cycle, and the read in any cycle follows the step that loaded MAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | Pulse that enables interrupts |
| mem_rdata | input | 16 | Word returned by memory in a read step |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Write data (MBR) |
| ctl_gates | output | 13 | Gate enables for the current step, bit positions per R3 |
| cyc_code | output | 2 | Current cycle code |
| step_idx | output | 2 | Current step within the cycle |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| ir_out | output | 16 | Instruction register |

## Verification
The bound checker watches every cycle for the following:
- the read and write strobes never collide;
- the fetch read comes after the PC-to-MAR step;
- PC advances by one across the second fetch step;
- the indirect state can only lead to execute, and the interrupt state can only lead to fetch;
- PC holds the handler address right after the second interrupt step;
- PC and accumulator do not move in steps with no gate active.

The data results only show up in the bench's scenarios. These cover the indirect address rewrite, the accumulated sums, the read-modify-write with its skip, the saved return address, and the enable gating of the request. In those scenarios, a behavioural model is compared against the outputs on every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int STEP_W = 2;

    typedef enum logic [1:0] {
        CYC_FETCH     = 2'b00,
        CYC_INDIRECT  = 2'b01,
        CYC_EXECUTE   = 2'b10,
        CYC_INTERRUPT = 2'b11
    } cyc_e;

    localparam int NUM_GATES     = 13;
    localparam int G_PC_TO_MAR   = 0;
    localparam int G_MEM_TO_MBR  = 1;
    localparam int G_PC_INC      = 2;
    localparam int G_MBR_TO_IR   = 3;
    localparam int G_IRA_TO_MAR  = 4;
    localparam int G_MBRA_TO_IRA = 5;
    localparam int G_PC_TO_MBR   = 6;
    localparam int G_SAVE_TO_MAR = 7;
    localparam int G_VEC_TO_PC   = 8;
    localparam int G_MBR_TO_MEM  = 9;
    localparam int G_ACC_ADD     = 10;
    localparam int G_MBR_INC     = 11;
    localparam int G_SKIP        = 12;

endpackage

// File: rtl/icu_sequencer.sv
module icu_sequencer
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              last_step,
    input  logic              ind_flag,
    input  logic              irq,
    input  logic              ien_set,
    output cyc_e              cyc_q,
    output logic [STEP_W-1:0] step_q
);

    cyc_e              cyc_d;
    logic [STEP_W-1:0] step_d;
    logic              ie_q;
    logic              ie_d;
    logic              enter_intr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= CYC_FETCH;
            step_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            cyc_q  <= cyc_d;
            step_q <= step_d;
            ie_q   <= ie_d;
        end
    end

    // next cycle and step
    always_comb begin
        cyc_d      = cyc_q;
        step_d     = step_q + STEP_W'(1);
        enter_intr = 1'b0;
        if (last_step) begin
            step_d = '0;
            unique case (cyc_q)
                CYC_FETCH:     cyc_d = ind_flag ? CYC_INDIRECT : CYC_EXECUTE;
                CYC_INDIRECT:  cyc_d = CYC_EXECUTE;
                CYC_EXECUTE: begin
                    if (irq && ie_q) begin
                        cyc_d      = CYC_INTERRUPT;
                        enter_intr = 1'b1;
                    end else begin
                        cyc_d = CYC_FETCH;
                    end
                end
                CYC_INTERRUPT: cyc_d = CYC_FETCH;
            endcase
        end
    end

    // interrupt enable: entry clears, pulse sets, clear wins
    always_comb begin
        ie_d = ie_q;
        if (enter_intr) begin
            ie_d = 1'b0;
        end else if (ien_set) begin
            ie_d = 1'b1;
        end
    end

endmodule

// File: rtl/icu_step_decoder.sv
module icu_step_decoder
    import icu_pkg::*;
#(
    parameter int OPC_W = 3
) (
    input  cyc_e                 cyc,
    input  logic [STEP_W-1:0]    step,
    input  logic [OPC_W-1:0]     opcode,
    input  logic                 mbr_zero,
    output logic [NUM_GATES-1:0] gates,
    output logic                 rd,
    output logic                 wr,
    output logic                 last_step
);

    logic is_add;
    logic is_isz;

    assign is_add = (opcode == OPC_W'(0));
    assign is_isz = (opcode == OPC_W'(1));

    always_comb begin
        gates     = '0;
        rd        = 1'b0;
        wr        = 1'b0;
        last_step = 1'b0;
        unique case (cyc)
            CYC_FETCH: begin
                case (step)
                    STEP_W'(0): gates[G_PC_TO_MAR] = 1'b1;
                    STEP_W'(1): begin
                        gates[G_MEM_TO_MBR] = 1'b1;
                        gates[G_PC_INC]     = 1'b1;
                        rd                  = 1'b1;
                    end
                    default: begin
                        gates[G_MBR_TO_IR] = 1'b1;
                        last_step          = 1'b1;
                    end
                endcase
            end
            CYC_INDIRECT: begin
                case (step)
                    STEP_W'(0): gates[G_IRA_TO_MAR] = 1'b1;
                    STEP_W'(1): begin
                        gates[G_MEM_TO_MBR] = 1'b1;
                        rd                  = 1'b1;
                    end
                    default: begin
                        gates[G_MBRA_TO_IRA] = 1'b1;
                        last_step            = 1'b1;
                    end
                endcase
            end
            CYC_EXECUTE: begin
                if (!(is_add || is_isz)) begin
                    last_step = 1'b1;
                end else begin
                    case (step)
                        STEP_W'(0): gates[G_IRA_TO_MAR] = 1'b1;
                        STEP_W'(1): begin
                            gates[G_MEM_TO_MBR] = 1'b1;
                            rd                  = 1'b1;
                        end
                        STEP_W'(2): begin
                            if (is_add) begin
                                gates[G_ACC_ADD] = 1'b1;
                                last_step        = 1'b1;
                            end else begin
                                gates[G_MBR_INC] = 1'b1;
                            end
                        end
                        default: begin
                            gates[G_MBR_TO_MEM] = 1'b1;
                            gates[G_SKIP]       = mbr_zero;
                            wr                  = 1'b1;
                            last_step           = 1'b1;
                        end
                    endcase
                end
            end
            CYC_INTERRUPT: begin
                case (step)
                    STEP_W'(0): gates[G_PC_TO_MBR] = 1'b1;
                    STEP_W'(1): begin
                        gates[G_SAVE_TO_MAR] = 1'b1;
                        gates[G_VEC_TO_PC]   = 1'b1;
                    end
                    default: begin
                        gates[G_MBR_TO_MEM] = 1'b1;
                        wr                  = 1'b1;
                        last_step           = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/icu_datapath.sv
module icu_datapath
    import icu_pkg::*;
#(
    parameter  int ADDR_W       = 12,
    parameter  int OPC_W        = 3,
    parameter  int SAVE_ADDR    = 'h0F0,
    parameter  int HANDLER_ADDR = 'h200,
    localparam int DATA_W       = 1 + OPC_W + ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_GATES-1:0] gates,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    pc_q,
    output logic [ADDR_W-1:0]    mar_q,
    output logic [DATA_W-1:0]    mbr_q,
    output logic [DATA_W-1:0]    ir_q,
    output logic [DATA_W-1:0]    acc_q,
    output logic [OPC_W-1:0]     opcode,
    output logic                 ind_flag,
    output logic                 mbr_zero
);

    localparam logic [ADDR_W-1:0] SAVE_VEC = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] HAND_VEC = ADDR_W'(HANDLER_ADDR);

    assign opcode   = ir_q[ADDR_W +: OPC_W];
    assign ind_flag = mbr_q[DATA_W-1];
    assign mbr_zero = (mbr_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (gates[G_VEC_TO_PC]) begin
            pc_q <= HAND_VEC;
        end else if (gates[G_PC_INC] || gates[G_SKIP]) begin
            pc_q <= pc_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
        end else if (gates[G_PC_TO_MAR]) begin
            mar_q <= pc_q;
        end else if (gates[G_IRA_TO_MAR]) begin
            mar_q <= ir_q[ADDR_W-1:0];
        end else if (gates[G_SAVE_TO_MAR]) begin
            mar_q <= SAVE_VEC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mbr_q <= '0;
        end else if (gates[G_MEM_TO_MBR]) begin
            mbr_q <= mem_rdata;
        end else if (gates[G_PC_TO_MBR]) begin
            mbr_q <= {{(DATA_W-ADDR_W){1'b0}}, pc_q};
        end else if (gates[G_MBR_INC]) begin
            mbr_q <= mbr_q + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
        end else if (gates[G_MBR_TO_IR]) begin
            ir_q <= mbr_q;
        end else if (gates[G_MBRA_TO_IRA]) begin
            ir_q[ADDR_W-1:0] <= mbr_q[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (gates[G_ACC_ADD]) begin
            acc_q <= acc_q + mbr_q;
        end
    end

endmodule

// File: rtl/insn_cycle_ctrl.sv
module insn_cycle_ctrl
    import icu_pkg::*;
#(
    parameter  int ADDR_W       = 12,
    parameter  int OPC_W        = 3,
    parameter  int SAVE_ADDR    = 'h0F0,
    parameter  int HANDLER_ADDR = 'h200,
    localparam int DATA_W       = 1 + OPC_W + ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 irq,
    input  logic                 ien_set,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [NUM_GATES-1:0] ctl_gates,
    output logic [1:0]           cyc_code,
    output logic [STEP_W-1:0]    step_idx,
    output logic [ADDR_W-1:0]    pc_out,
    output logic [DATA_W-1:0]    acc_out,
    output logic [DATA_W-1:0]    ir_out
);

    cyc_e              cyc;
    logic [STEP_W-1:0] step;
    logic              last_step;
    logic              ind_flag;
    logic              mbr_zero;
    logic [OPC_W-1:0]  opcode;

    icu_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .last_step (last_step),
        .ind_flag  (ind_flag),
        .irq       (irq),
        .ien_set   (ien_set),
        .cyc_q     (cyc),
        .step_q    (step)
    );

    icu_step_decoder #(.OPC_W(OPC_W)) u_dec (
        .cyc       (cyc),
        .step      (step),
        .opcode    (opcode),
        .mbr_zero  (mbr_zero),
        .gates     (ctl_gates),
        .rd        (mem_rd),
        .wr        (mem_wr),
        .last_step (last_step)
    );

    icu_datapath #(
        .ADDR_W       (ADDR_W),
        .OPC_W        (OPC_W),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .gates     (ctl_gates),
        .mem_rdata (mem_rdata),
        .pc_q      (pc_out),
        .mar_q     (mem_addr),
        .mbr_q     (mem_wdata),
        .ir_q      (ir_out),
        .acc_q     (acc_out),
        .opcode    (opcode),
        .ind_flag  (ind_flag),
        .mbr_zero  (mbr_zero)
    );

    assign cyc_code = cyc;
    assign step_idx = step;

endmodule

// File: rtl/icu_checker.sv
module icu_checker
    import icu_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 16,
    parameter int HANDLER_ADDR = 'h200
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [NUM_GATES-1:0] ctl_gates,
    input logic [1:0]           cyc_code,
    input logic [STEP_W-1:0]    step_idx,
    input logic [ADDR_W-1:0]    pc_out,
    input logic [DATA_W-1:0]    acc_out
);

    assert_rd_wr_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_mar_before_read_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && cyc_code == CYC_FETCH) |-> $past(ctl_gates[G_PC_TO_MAR]));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cyc_code == CYC_FETCH && step_idx == STEP_W'(1))
        |=> (pc_out == $past(pc_out) + ADDR_W'(1)));

    assert_indirect_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_code == CYC_INDIRECT)
        |=> (cyc_code == CYC_INDIRECT || cyc_code == CYC_EXECUTE));

    assert_intr_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_code == CYC_INTERRUPT)
        |=> (cyc_code == CYC_INTERRUPT || cyc_code == CYC_FETCH));

    assert_handler_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_code == CYC_INTERRUPT && step_idx == STEP_W'(1))
        |=> (pc_out == ADDR_W'(HANDLER_ADDR)));

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_gates == '0) |=> ($stable(pc_out) && $stable(acc_out)));

    assert_step_range_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_code != CYC_EXECUTE) |-> (step_idx != STEP_W'(3)));

endmodule

bind insn_cycle_ctrl icu_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ctl_gates (ctl_gates),
    .cyc_code  (cyc_code),
    .step_idx  (step_idx),
    .pc_out    (pc_out),
    .acc_out   (acc_out)
);

// File: tb/tb_insn_cycle_ctrl.sv
module tb_insn_cycle_ctrl;
    import icu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int OPC_W      = 3;
    localparam int DATA_W     = 16;
    localparam int SAVE       = 'h0F0;
    localparam int HAND       = 'h200;
    localparam int MEMW       = 1 << ADDR_W;

    logic                 clk, rst, irq, ien_set;
    logic [DATA_W-1:0]    mem_rdata, mem_wdata, acc_out, ir_out;
    logic                 mem_rd, mem_wr;
    logic [ADDR_W-1:0]    mem_addr, pc_out;
    logic [NUM_GATES-1:0] ctl_gates;
    logic [1:0]           cyc_code;
    logic [1:0]           step_idx;

    insn_cycle_ctrl #(
        .ADDR_W(ADDR_W), .OPC_W(OPC_W), .SAVE_ADDR(SAVE), .HANDLER_ADDR(HAND)
    ) dut (
        .clk(clk), .rst(rst), .irq(irq), .ien_set(ien_set),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ctl_gates(ctl_gates),
        .cyc_code(cyc_code), .step_idx(step_idx), .pc_out(pc_out),
        .acc_out(acc_out), .ir_out(ir_out)
    );

    logic [DATA_W-1:0] tbmem [MEMW];
    assign mem_rdata = tbmem[mem_addr];

    int  checks = 0;
    int  fails  = 0;
    bit  cmp_on = 0;
    bit  done   = 0;
    int  m_cyc, m_step, m_pc, m_mar, m_mbr, m_ir, m_acc;
    bit  m_ie;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (time %0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic int m_op(int ir);
        return (ir >> 12) & 7;
    endfunction

    function automatic int m_len(int cyc, int op);
        if (cyc != 2) return 3;
        if (op == 0) return 3;
        if (op == 1) return 4;
        return 1;
    endfunction

    function automatic int m_gates(int cyc, int step, int op, int mbr);
        case (cyc)
            0: case (step)
                   0: return 1 << G_PC_TO_MAR;
                   1: return (1 << G_MEM_TO_MBR) | (1 << G_PC_INC);
                   default: return 1 << G_MBR_TO_IR;
               endcase
            1: case (step)
                   0: return 1 << G_IRA_TO_MAR;
                   1: return 1 << G_MEM_TO_MBR;
                   default: return 1 << G_MBRA_TO_IRA;
               endcase
            2: begin
                if (op > 1) return 0;
                case (step)
                    0: return 1 << G_IRA_TO_MAR;
                    1: return 1 << G_MEM_TO_MBR;
                    2: return (op == 0) ? (1 << G_ACC_ADD) : (1 << G_MBR_INC);
                    default: return (1 << G_MBR_TO_MEM) | ((mbr == 0) ? (1 << G_SKIP) : 0);
                endcase
            end
            default: case (step)
                   0: return 1 << G_PC_TO_MBR;
                   1: return (1 << G_SAVE_TO_MAR) | (1 << G_VEC_TO_PC);
                   default: return 1 << G_MBR_TO_MEM;
               endcase
        endcase
    endfunction

    function automatic int m_rd(int cyc, int step, int op);
        return (step == 1 && (cyc == 0 || cyc == 1 || (cyc == 2 && op < 2))) ? 1 : 0;
    endfunction

    function automatic int m_wr(int cyc, int step, int op);
        return ((cyc == 3 && step == 2) || (cyc == 2 && op == 1 && step == 3)) ? 1 : 0;
    endfunction

    function automatic string tag_of(int cyc, int op);
        case (cyc)
            0: return "R3";
            1: return "R4";
            3: return "R8";
            default: return (op == 0) ? "R5" : (op == 1) ? "R6" : "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_cyc = 0; m_step = 0; m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_acc = 0; m_ie = 0;
    endtask

    task automatic model_step(bit irq_s, bit ien_s);
        int  op;
        bit  last;
        bit  enter;
        op    = m_op(m_ir);
        last  = (m_step == m_len(m_cyc, op) - 1);
        enter = 0;
        case (m_cyc)
            0: case (m_step)
                   0: m_mar = m_pc;
                   1: begin m_mbr = int'(tbmem[m_mar]); m_pc = (m_pc + 1) & 'hFFF; end
                   default: m_ir = m_mbr;
               endcase
            1: case (m_step)
                   0: m_mar = m_ir & 'hFFF;
                   1: m_mbr = int'(tbmem[m_mar]);
                   default: m_ir = (m_ir & 'hF000) | (m_mbr & 'hFFF);
               endcase
            2: if (op < 2) begin
                   case (m_step)
                       0: m_mar = m_ir & 'hFFF;
                       1: m_mbr = int'(tbmem[m_mar]);
                       2: if (op == 0) m_acc = (m_acc + m_mbr) & 'hFFFF;
                          else m_mbr = (m_mbr + 1) & 'hFFFF;
                       default: if (m_mbr == 0) m_pc = (m_pc + 1) & 'hFFF;
                   endcase
               end
            default: case (m_step)
                   0: m_mbr = m_pc;
                   1: begin m_mar = SAVE; m_pc = HAND; end
                   default: ;
               endcase
        endcase
        if (last) begin
            case (m_cyc)
                0: m_cyc = ((m_ir >> 15) & 1) ? 1 : 2;
                1: m_cyc = 2;
                2: if (irq_s && m_ie) begin m_cyc = 3; enter = 1; end else m_cyc = 0;
                default: m_cyc = 0;
            endcase
            m_step = 0;
        end else begin
            m_step++;
        end
        if (enter) m_ie = 0;
        else if (ien_s) m_ie = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
            for (int i = 0; i < MEMW; i++) tbmem[i] <= '0;
            tbmem[0] <= 16'h0100; tbmem[1] <= 16'h8101; tbmem[2] <= 16'h1103;
            tbmem[3] <= 16'h0100; tbmem[4] <= 16'h1104; tbmem[5] <= 16'h7000;
            tbmem[6] <= 16'h9105; tbmem[7] <= 16'h0100; tbmem[8] <= 16'h0102;
            tbmem['h100] <= 16'h0005; tbmem['h101] <= 16'h0102; tbmem['h102] <= 16'h0007;
            tbmem['h103] <= 16'hFFFF; tbmem['h104] <= 16'h0003; tbmem['h105] <= 16'h0106;
            tbmem['h106] <= 16'hFFFF;
        end else begin
            model_step(irq, ien_set);
            if (mem_wr) tbmem[mem_addr] <= mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            int    op;
            int    erd;
            int    ewr;
            string tg;
            op  = m_op(m_ir);
            tg  = tag_of(m_cyc, op);
            erd = m_rd(m_cyc, m_step, op);
            ewr = m_wr(m_cyc, m_step, op);
            check("R2", "cycle code", int'(cyc_code), m_cyc);
            check("R2", "step index", int'(step_idx), m_step);
            check(tg, "gate vector", int'(ctl_gates), m_gates(m_cyc, m_step, op, m_mbr));
            check("R10", "read strobe", int'(mem_rd), erd);
            check("R10", "write strobe", int'(mem_wr), ewr);
            if (erd == 1 || ewr == 1) check("R10", "address", int'(mem_addr), m_mar);
            if (ewr == 1) check(tg, "write data", int'(mem_wdata), m_mbr);
            check(tg, "pc", int'(pc_out), m_pc);
            check(tg, "accumulator", int'(acc_out), m_acc);
            check(tg, "ir", int'(ir_out), m_ir);
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seen;
        int ret_pc;
        rst = 1'b1; irq = 1'b0; ien_set = 1'b0;
        repeat (3) @(posedge clk);
        cmp_on = 1;
        @(negedge clk);
        check("R1", "reset cycle code", int'(cyc_code), 0);
        check("R1", "reset step", int'(step_idx), 0);
        check("R1", "reset pc", int'(pc_out), 0);
        check("R1", "reset accumulator", int'(acc_out), 0);
        rst = 1'b0;

        // program run with request held high but interrupts disabled
        irq  = 1'b1;
        seen = 0;
        for (int n = 0; n < 500; n++) begin
            @(negedge clk);
            if (cyc_code == 2'b11) seen++;
            if (pc_out == 12'd9 && cyc_code == 2'b00 && step_idx == 2'd0) break;
        end
        check("R9", "interrupts while disabled", seen, 0);
        check("R5", "accumulated sum", int'(acc_out), 'h13);
        check("R6", "isz direct wrap", int'(tbmem['h103]), 0);
        check("R6", "isz no wrap", int'(tbmem['h104]), 4);
        check("R6", "isz indirect wrap", int'(tbmem['h106]), 0);
        check("R4", "pointer word untouched", int'(tbmem['h105]), 'h106);

        // enable and take an interrupt
        ien_set = 1'b1;
        @(negedge clk);
        ien_set = 1'b0;
        seen = 0;
        for (int n = 0; n < 100; n++) begin
            if (cyc_code == 2'b11) begin seen = 1; break; end
            @(negedge clk);
        end
        check("R9", "interrupt taken once enabled", seen, 1);
        ret_pc = int'(pc_out);
        for (int n = 0; n < 10; n++) begin
            if (cyc_code == 2'b00) break;
            @(negedge clk);
        end
        check("R8", "handler pc", int'(pc_out), HAND);
        check("R8", "saved return pc", int'(tbmem[SAVE]), ret_pc);
        seen = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (cyc_code == 2'b11) seen++;
        end
        check("R8", "enable cleared on entry", seen, 0);

        // mixed request and enable traffic
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            irq     = ($urandom_range(0, 1) == 1);
            ien_set = ($urandom_range(0, 15) == 0);
        end
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule